// File: doc/BRIEF.md
# Rotation-Aware Window Address Command Sequencer

This block turns a display rotation code and the start coordinate of a drawing window into the short command sequence that a grayscale panel controller needs before pixel data can follow. One pulse on `start` while the block is idle captures the rotation and the coordinate. The block then presents six command bytes, one at a time, on a valid/ready byte stream. The data/command select line stays at the command level for the whole sequence.

The first two bytes set the orientation. One byte is the RAM address control: it picks whether the address advances column-first or page-first, and it always selects positive increment and wrap-around. The other byte is the panel mapping: it sets the X and Y mirror bits and always selects most-significant-nibble-last. The last four bytes carry the window origin. These are the column address as a low and a high nibble, then the page address as a low and a high nibble. At 90 and 270 degrees the roles of x and y swap. Each page covers two pixel rows, so the page value is always a coordinate divided by two.

Top module: `lcd_orient_addr_gen`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `cmd_dc` is 0.
- R2: A `start` pulse while `cmd_valid` is 0 is captured at that clock edge. `cmd_valid` is 1 from the next cycle. Exactly six bytes then follow in this order: RAM control, mapping, column low, column high, page low, page high. Each byte advances on a cycle where `cmd_valid` and `cmd_ready` are both 1.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_byte` and `cmd_valid` stay unchanged on the next cycle.
- R4: The RAM control byte is 0x89 for rotation code 0 (0°) and code 2 (180°). It is 0x8B for code 1 (90°) and code 3 (270°). Bit 1 set means page-first. Bit 0 is wrap and is always 1. Bit 2 is direction and is always 0 (positive).
- R5: The mapping byte is 0xC0 | mirrorY<<2 | mirrorX<<1, with bit 0 (nibble order) always 0. Its value is 0xC2 for 0°, 0xC0 for 90°, 0xC4 for 180° and 0xC6 for 270°.
- R6: For column value c, the column bytes are c & 0x0F, then 0x10 | (c >> 4). c is x at 0° and 180°, and y at 90° and 270°.
- R7: For page value p, the page bytes are 0x60 | (p & 0x0F), then 0x70 | (p >> 4). p is y>>1 at 0° and 180°, and x>>1 at 90° and 270°.
- R8: Rotation codes 4 to 7 produce exactly the bytes of code 0.
- R9: A `start` pulse while `cmd_valid` is 1 is ignored. The sequence in progress continues with its captured values and does not restart.
- R10: After the sixth byte is accepted, `cmd_valid` is 0 on the next cycle, and a new `start` is accepted from then on.
- R11: `cmd_dc` is 0 in every cycle, including every cycle where `cmd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one command sequence |
| rot_code | input | 3 | Rotation: 0=0°, 1=90°, 2=180°, 3=270°; 4 to 7 act as 0 |
| win_x | input | 8 | Window start x coordinate |
| win_y | input | 8 | Window start y coordinate |
| cmd_ready | input | 1 | Sink accepts the current byte |
| cmd_valid | output | 1 | A command byte is presented |
| cmd_byte | output | 8 | Command byte |
| cmd_dc | output | 1 | Data/command select, 0 = command |

## Verification
The bench drives inputs and samples outputs on the falling edge. A `start` sampled at one rising edge must show the RAM control byte as valid at the next falling edge, one register later. Each later byte must appear at the falling edge after the rising edge that completed the previous handshake. After the sixth handshake, `cmd_valid` must read 0 at the following falling edge. Stall cycles hold `cmd_ready` low for one period and re-check the same byte before releasing it. A second `start` raised mid-sequence is followed by checks that the remaining bytes still match the first request.

// File: rtl/oag_pkg.sv
package oag_pkg;
   typedef enum logic [1:0] {
      ROT_0   = 2'd0,
      ROT_90  = 2'd1,
      ROT_180 = 2'd2,
      ROT_270 = 2'd3
   } rot_e;

   typedef struct packed {
      logic page_first;
      logic mirror_y;
      logic mirror_x;
   } orient_t;

   localparam int N_CMD = 6;
   localparam int IDX_W = $clog2(N_CMD);

   function automatic orient_t orient_of(rot_e r);
      orient_t o;
      unique case (r)
         ROT_90:  o = '{page_first: 1'b1, mirror_y: 1'b0, mirror_x: 1'b0};
         ROT_180: o = '{page_first: 1'b0, mirror_y: 1'b1, mirror_x: 1'b0};
         ROT_270: o = '{page_first: 1'b1, mirror_y: 1'b1, mirror_x: 1'b1};
         default: o = '{page_first: 1'b0, mirror_y: 1'b0, mirror_x: 1'b1};
      endcase
      return o;
   endfunction
endpackage

// File: rtl/oag_rot_decode.sv
module oag_rot_decode
   import oag_pkg::*;
#(
   parameter int ROT_W = 3
) (
   input  logic [ROT_W-1:0] rot_code,
   output rot_e             rot
);
   generate
      if (ROT_W < 2) begin : g_bad_width
         $error("oag_rot_decode: ROT_W must be at least 2");
      end else if (ROT_W == 2) begin : g_direct
         assign rot = rot_e'(rot_code);
      end else begin : g_clamp
         logic upper_set;
         assign upper_set = |rot_code[ROT_W-1:2];
         assign rot       = upper_set ? ROT_0 : rot_e'(rot_code[1:0]);
      end
   endgenerate
endmodule

// File: rtl/oag_byte_mux.sv
module oag_byte_mux
   import oag_pkg::*;
#(
   parameter int COORD_W = 8
) (
   input  rot_e             rot,
   input  logic [COORD_W-1:0] x,
   input  logic [COORD_W-1:0] y,
   input  logic [IDX_W-1:0]   idx,
   output logic [7:0]         byte_o
);
   localparam int PAD_W = 8 - COORD_W;

   generate
      if (COORD_W < 2 || COORD_W > 8) begin : g_bad_width
         $error("oag_byte_mux: COORD_W must lie in 2..8");
      end
   endgenerate

   orient_t            ori;
   logic [COORD_W-1:0] col_src;
   logic [COORD_W-1:0] row_src;
   logic [7:0]         col8;
   logic [7:0]         page8;

   assign ori     = orient_of(rot);
   assign col_src = ori.page_first ? y : x;
   assign row_src = ori.page_first ? x : y;

   generate
      if (PAD_W > 0) begin : g_pad
         assign col8  = {{PAD_W{1'b0}}, col_src};
         assign page8 = {{PAD_W{1'b0}}, row_src} >> 1;
      end else begin : g_full
         assign col8  = col_src;
         assign page8 = row_src >> 1;
      end
   endgenerate

   always_comb begin
      unique case (idx)
         IDX_W'(0): byte_o = {4'h8, 1'b1, 1'b0, ori.page_first, 1'b1};
         IDX_W'(1): byte_o = {4'hC, 1'b0, ori.mirror_y, ori.mirror_x, 1'b0};
         IDX_W'(2): byte_o = {4'h0, col8[3:0]};
         IDX_W'(3): byte_o = {4'h1, col8[7:4]};
         IDX_W'(4): byte_o = {4'h6, page8[3:0]};
         default:   byte_o = {4'h7, page8[7:4]};
      endcase
   end
endmodule

// File: rtl/oag_seq.sv
module oag_seq
   import oag_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ready,
   output logic             valid,
   output logic             load,
   output logic [IDX_W-1:0] idx
);
   logic last;

   assign load = start && !valid;
   assign last = (idx == IDX_W'(N_CMD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         idx   <= '0;
      end else if (load) begin
         valid <= 1'b1;
         idx   <= '0;
      end else if (valid && ready) begin
         if (last) begin
            valid <= 1'b0;
            idx   <= '0;
         end else begin
            idx <= idx + IDX_W'(1);
         end
      end
   end

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start && !valid |=> valid && idx == '0);

   p_hold_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(idx));

   p_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid) |-> $past(ready) && $past(idx) == IDX_W'(N_CMD - 1));

   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid && start && !ready |=> $stable(idx));
endmodule

// File: rtl/lcd_orient_addr_gen.sv
module lcd_orient_addr_gen
   import oag_pkg::*;
#(
   parameter int ROT_W   = 3,
   parameter int COORD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ROT_W-1:0]   rot_code,
   input  logic [COORD_W-1:0] win_x,
   input  logic [COORD_W-1:0] win_y,
   input  logic               cmd_ready,
   output logic               cmd_valid,
   output logic [7:0]         cmd_byte,
   output logic               cmd_dc
);
   rot_e               rot_in;
   rot_e               rot_q;
   logic [COORD_W-1:0] x_q;
   logic [COORD_W-1:0] y_q;
   logic               load;
   logic [IDX_W-1:0]   idx;

   oag_rot_decode #(.ROT_W(ROT_W)) u_dec (
      .rot_code (rot_code),
      .rot      (rot_in)
   );

   oag_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .ready (cmd_ready),
      .valid (cmd_valid),
      .load  (load),
      .idx   (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_q <= ROT_0;
         x_q   <= '0;
         y_q   <= '0;
      end else if (load) begin
         rot_q <= rot_in;
         x_q   <= win_x;
         y_q   <= win_y;
      end
   end

   oag_byte_mux #(.COORD_W(COORD_W)) u_mux (
      .rot    (rot_q),
      .x      (x_q),
      .y      (y_q),
      .idx    (idx),
      .byte_o (cmd_byte)
   );

   assign cmd_dc = 1'b0;

   p_hold_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte));

   p_ctrl_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> cmd_byte[7:3] == 5'b10001 && !cmd_byte[2] && cmd_byte[0]);

   p_capture_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && $past(cmd_valid) |-> $stable(x_q) && $stable(y_q));
endmodule

// File: tb/test_lcd_orient_addr_gen.sv
module test_lcd_orient_addr_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] rot_code = '0;
   logic [7:0] win_x = '0;
   logic [7:0] win_y = '0;
   logic       cmd_ready = 1'b0;
   logic       cmd_valid;
   logic [7:0] cmd_byte;
   logic       cmd_dc;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   lcd_orient_addr_gen i_lcd_orient_addr_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rot_code  (rot_code),
      .win_x     (win_x),
      .win_y     (win_y),
      .cmd_ready (cmd_ready),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .cmd_dc    (cmd_dc)
   );

   function automatic logic [7:0] exp_byte(logic [2:0] r, logic [7:0] x, logic [7:0] y, int i);
      logic [1:0] rr;
      logic [7:0] c, p;
      rr = (r > 3'd3) ? 2'd0 : r[1:0];
      c  = rr[0] ? y : x;
      p  = (rr[0] ? x : y) >> 1;
      case (i)
         0: return rr[0] ? 8'h8B : 8'h89;
         1: return (rr == 2'd0) ? 8'hC2 : (rr == 2'd1) ? 8'hC0 : (rr == 2'd2) ? 8'hC4 : 8'hC6;
         2: return {4'h0, c[3:0]};
         3: return {4'h1, c[7:4]};
         4: return {4'h6, p[3:0]};
         default: return {4'h7, p[7:4]};
      endcase
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One full sequence; stall_mask holds ready low once before byte i;
   // busy_at >= 0 raises a second start while that byte is presented.
   task automatic run_seq(string req, logic [2:0] r, logic [7:0] x, logic [7:0] y,
                          logic [5:0] stall_mask, int busy_at);
      @(negedge clk);
      start = 1'b1; rot_code = r; win_x = x; win_y = y;
      @(negedge clk);
      start = 1'b0;
      check("R2 valid one cycle after start", {7'd0, cmd_valid}, 8'd1);
      for (int i = 0; i < 6; i++) begin
         if (stall_mask[i]) begin
            cmd_ready = 1'b0;
            @(negedge clk);
            check("R3 held valid", {7'd0, cmd_valid}, 8'd1);
            check("R3 held byte", cmd_byte, exp_byte(r, x, y, i));
         end
         check(req, cmd_byte, exp_byte(r, x, y, i));
         check("R11 dc low", {7'd0, cmd_dc}, 8'd0);
         if (i == busy_at) begin
            start = 1'b1; rot_code = ~r; win_x = ~x; win_y = ~y;
         end
         cmd_ready = 1'b1;
         @(negedge clk);
         cmd_ready = 1'b0;
         start = 1'b0;
      end
      check("R10 valid low after sixth byte", {7'd0, cmd_valid}, 8'd0);
   endtask

   task automatic t_reset;
      check("R1 valid at reset", {7'd0, cmd_valid}, 8'd0);
      check("R1 dc at reset", {7'd0, cmd_dc}, 8'd0);
   endtask

   task automatic t_rotations;
      run_seq("R4 R5 R6 R7 rot 0",   3'd0, 8'hA5, 8'h3C, 6'b000000, -1);
      run_seq("R4 R5 R6 R7 rot 90",  3'd1, 8'hA5, 8'h3C, 6'b000101, -1);
      run_seq("R4 R5 R6 R7 rot 180", 3'd2, 8'h17, 8'h9F, 6'b100000, -1);
      run_seq("R4 R5 R6 R7 rot 270", 3'd3, 8'h17, 8'h9F, 6'b010010, -1);
   endtask

   task automatic t_illegal_rot;
      run_seq("R8 code 5", 3'd5, 8'h6B, 8'h44, 6'b000000, -1);
      run_seq("R8 code 7", 3'd7, 8'h01, 8'hFE, 6'b001000, -1);
   endtask

   task automatic t_bounds;
      run_seq("R6 R7 max window", 3'd0, 8'd239, 8'd159, 6'b000000, -1);
      run_seq("R6 R7 max swapped", 3'd3, 8'd239, 8'd159, 6'b000000, -1);
      run_seq("R7 odd row to page 0", 3'd2, 8'd0, 8'd1, 6'b000000, -1);
   endtask

   task automatic t_busy_start;
      run_seq("R9 start while busy", 3'd1, 8'h5A, 8'h21, 6'b000100, 2);
      // R10: back-to-back request accepted right after the previous one
      run_seq("R10 next request", 3'd2, 8'h33, 8'h66, 6'b000000, -1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rotations();
      t_illegal_rot();
      t_bounds();
      t_busy_start();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule